// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a bank of independent 64-bit down-counters behind a small synchronous register bus. Each channel counts in its own timer clock domain at the timer clock rate divided by a power of two. It either reloads itself from a programmed interval each time it expires (periodic) or stops after one expiry (single-shot). Every expiry raises a per-channel pending flag. A shared mask turns the unmasked pending flags into a single interrupt line.

Software programs a channel in four steps:
- write the interval words;
- set the enable and load bits in the channel's control word;
- later acknowledge expiries by writing ones to the pending register;
- read the count as a low word followed by a high word.

The low-word read freezes the matching high word, so the 64-bit value stays consistent. Programming the interval to all ones in the low word makes the channel a free-running counter. Software takes a rising timestamp by inverting the count.

Only the enable level, a load request toggle and acknowledge toggles cross into the timer domain, through two-flop synchronizers. The interval, prescale and mode fields are treated as stable while a channel is idle. Expiries and the running count return to the bus domain through toggle handshakes. Each channel's timer side is a three-state machine:
- `ST_IDLE`: the channel is not counting.
- `ST_RUN`: the channel counts down.
- `ST_HALT`: a single-shot channel has expired and is waiting.

The transitions are:
- idle to run, when the synchronized enable is seen;
- run to idle, when the enable is withdrawn;
- run to halt, on a single-shot expiry;
- halt to idle, when the enable is withdrawn;
- from any state, a load request goes to run if enabled and to idle otherwise.

Top module: `dtmr_top`

## Requirements
- R1: After reset every register reads 0: mask (0x00), pending (0x04), and each channel's control, interval low/high and count low/high words; the interrupt output is low.
- R2: Channel n's words are at 0x10+0x20*n: +0x0 control, +0x4 interval low, +0x8 interval high, +0xC count low, +0x10 count high. The control bits are: bit0 enable, bit1 load, bits 6:4 prescale N, bit7 single-shot (0 = periodic). All other control bits read 0. The interval words read back as written.
- R3: Writing 1 to the load bit copies the 64-bit interval into the counter, whether or not the channel is enabled. The load bit reads 1 until the copy is done, then reads 0 without further writes.
- R4: An enabled channel decrements once every 2^N timer clocks, where N is its prescale field.
- R5: In periodic mode, a channel at 0 sets its pending bit on its next tick, reloads the interval and keeps its enable. Successive expiries are (interval+1)*2^N timer clocks apart.
- R6: In single-shot mode, a channel expires (interval+1)*2^N timer clocks after its load. It then sets its pending bit, clears its own enable bit, holds the count at 0 and does not expire again.
- R7: Writing the pending register (0x04) clears exactly the bits written as 1. Bits written as 0 are unchanged. An expiry in the same cycle wins over a clear.
- R8: The interrupt output is high exactly when some channel has both its pending bit and its mask bit (bit n of 0x00) set.
- R9: Reading count low captures the channel's high count word. A later read of count high returns that captured word, so {high, low} is one consistent sample.
- R10: After the enable bit is cleared, the channel keeps counting for at most about three timer clocks (two synchronizer stages plus one), then its count stays frozen.
- R11: With interval low 0xFFFFFFFF, high 0, in periodic mode, the bitwise inverse of the low count word rises at the tick rate.
- R12: Channels are independent. Programming, expiring or acknowledging one channel changes no other channel's count, control or pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| tclk | input | 1 | Timer clock |
| trst_n | input | 1 | Timer-domain asynchronous reset, active low |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next clk edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with three channels and an 8-bit address. The third channel therefore decodes from a channel index with its upper bit pattern in use, and a periodic channel can run in the background while another runs single-shot and a third stays frozen. The timer clock runs at a period unrelated to the 100 MHz bus clock, so the synchronizer and handshake paths see shifting phase relations. Prescale values up to 2 are randomised against intervals, and fixed cases cover prescale 3, prescale 7 readback, and a count that crosses the high-word boundary.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int DATA_W      = 32;
    localparam int PS_W        = 3;
    localparam int DIV_W       = (1 << PS_W) - 1;
    localparam int OFS_MASK    = 'h00;
    localparam int OFS_PEND    = 'h04;
    localparam int OFS_CH0     = 'h10;
    localparam int STRIDE_LG   = 5;

    typedef enum logic [2:0] {
        SUB_CTRL   = 3'd0,
        SUB_IVL_LO = 3'd1,
        SUB_IVL_HI = 3'd2,
        SUB_CNT_LO = 3'd3,
        SUB_CNT_HI = 3'd4
    } sub_e;

    typedef struct packed {
        logic            oneshot;
        logic [PS_W-1:0] ps;
        logic            load;
        logic            en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_e;
endpackage

// File: rtl/dtmr_sync.sv
module dtmr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic            clk_t,
    input  logic            rst_t_n,
    input  logic            en_a,
    input  logic            ld_req_a,
    input  logic            snap_ack_a,
    input  logic            oneshot,
    input  logic [PS_W-1:0] ps,
    input  logic [CW-1:0]   ivl,
    output logic            ld_ack,
    output logic            exp_tgl,
    output logic [CW-1:0]   snap,
    output logic            snap_tgl
);
    logic [2:0] s_q;
    logic       en_s, ld_s, ack_s;

    dtmr_sync #(.W(3)) u_sync (
        .clk  (clk_t),
        .rst_n(rst_t_n),
        .d    ({en_a, ld_req_a, snap_ack_a}),
        .q    (s_q)
    );
    assign en_s  = s_q[2];
    assign ld_s  = s_q[1];
    assign ack_s = s_q[0];

    run_e             state, nstate;
    logic [CW-1:0]    cnt;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] div_lim;
    logic             ld_hit, tick, at_zero;

    assign ld_hit  = (ld_s != ld_ack);
    assign div_lim = DIV_W'((32'd1 << ps) - 32'd1);
    assign tick    = (div == div_lim);
    assign at_zero = (cnt == '0);

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (en_s) nstate = ST_RUN;
            ST_RUN: begin
                if (!en_s)                          nstate = ST_IDLE;
                else if (tick && at_zero && oneshot) nstate = ST_HALT;
            end
            ST_HALT: if (!en_s) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
        if (ld_hit) nstate = en_s ? ST_RUN : ST_IDLE;
    end

    // state register
    always_ff @(posedge clk_t or negedge rst_t_n) begin
        if (!rst_t_n) state <= ST_IDLE;
        else          state <= nstate;
    end

    // outputs: counter, divider, handshakes
    always_ff @(posedge clk_t or negedge rst_t_n) begin
        if (!rst_t_n) begin
            cnt      <= '0;
            div      <= '0;
            ld_ack   <= 1'b0;
            exp_tgl  <= 1'b0;
            snap     <= '0;
            snap_tgl <= 1'b0;
        end else begin
            if (ld_hit) begin
                cnt    <= ivl;
                div    <= '0;
                ld_ack <= ld_s;
            end else if (state == ST_RUN && en_s) begin
                if (tick) begin
                    div <= '0;
                    if (at_zero) begin
                        exp_tgl <= ~exp_tgl;
                        if (!oneshot) cnt <= ivl;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
            if (ack_s == snap_tgl) begin
                snap     <= cnt;
                snap_tgl <= ~snap_tgl;
            end
        end
    end
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tclk,
    input  logic              trst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CW   = 2 * DATA_W;
    localparam int CH_W = AW - STRIDE_LG;

    logic [AW-1:0]   ofs;
    logic [CH_W-1:0] ch_sel;
    logic [2:0]      sub;
    logic            in_ch;
    logic [NCH-1:0]  acc;

    assign ofs    = bus_addr - AW'(OFS_CH0);
    assign ch_sel = ofs[AW-1:STRIDE_LG];
    assign sub    = ofs[4:2];
    assign in_ch  = (bus_addr >= AW'(OFS_CH0)) && (ofs[1:0] == 2'b00) && (sub <= 3'd4);

    logic [NCH-1:0] irq_en_q, stat_q, exp_evt;
    logic [NCH-1:0] en_vec, rl_vec, os_vec;
    logic [NCH-1:0] ld_ack_t, exp_t, stgl_t;
    logic [CW-1:0]  snap_t [NCH];
    ctrl_t          ctrl_v [NCH];
    logic [CW-1:0]  ivl_v  [NCH];
    logic [CW-1:0]  cnt_v  [NCH];
    logic [DATA_W-1:0] hi_v [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ctrl_t             ctrl_r;
        logic [CW-1:0]     ivl_r, cnt_r;
        logic [DATA_W-1:0] hi_r;
        logic              ld_req_r, snp_seen_r, exp_prev_r;
        logic [2:0]        bs_q;
        logic              ack_s, exp_s, snp_s, wr_here, ld_done;

        assign acc[i] = in_ch && (ch_sel == CH_W'(i));

        dtmr_sync #(.W(3)) u_bsync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    ({ld_ack_t[i], exp_t[i], stgl_t[i]}),
            .q    (bs_q)
        );
        assign ack_s   = bs_q[2];
        assign exp_s   = bs_q[1];
        assign snp_s   = bs_q[0];
        assign wr_here = bus_wr && acc[i];
        assign ld_done = ctrl_r.load && (ack_s == ld_req_r);
        assign exp_evt[i] = (exp_s != exp_prev_r);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_r     <= '0;
                ivl_r      <= '0;
                cnt_r      <= '0;
                hi_r       <= '0;
                ld_req_r   <= 1'b0;
                snp_seen_r <= 1'b0;
                exp_prev_r <= 1'b0;
            end else begin
                exp_prev_r <= exp_s;
                if (snp_s != snp_seen_r) begin
                    cnt_r      <= snap_t[i];
                    snp_seen_r <= snp_s;
                end
                if (exp_evt[i] && ctrl_r.oneshot) ctrl_r.en <= 1'b0;
                if (ld_done) ctrl_r.load <= 1'b0;
                if (wr_here) begin
                    case (sub)
                        SUB_CTRL: begin
                            ctrl_r.en      <= bus_wdata[0];
                            ctrl_r.ps      <= bus_wdata[6:4];
                            ctrl_r.oneshot <= bus_wdata[7];
                            if (bus_wdata[1] && (!ctrl_r.load || ld_done)) begin
                                ctrl_r.load <= 1'b1;
                                ld_req_r    <= ~ld_req_r;
                            end
                        end
                        SUB_IVL_LO: ivl_r[DATA_W-1:0]  <= bus_wdata;
                        SUB_IVL_HI: ivl_r[CW-1:DATA_W] <= bus_wdata;
                        default: ;
                    endcase
                end
                if (bus_rd && acc[i] && sub == SUB_CNT_LO) hi_r <= cnt_r[CW-1:DATA_W];
            end
        end

        assign ctrl_v[i] = ctrl_r;
        assign ivl_v[i]  = ivl_r;
        assign cnt_v[i]  = cnt_r;
        assign hi_v[i]   = hi_r;
        assign en_vec[i] = ctrl_r.en;
        assign rl_vec[i] = ctrl_r.load;
        assign os_vec[i] = ctrl_r.oneshot;

        dtmr_chan #(.CW(CW)) u_chan (
            .clk_t     (tclk),
            .rst_t_n   (trst_n),
            .en_a      (ctrl_r.en),
            .ld_req_a  (ld_req_r),
            .snap_ack_a(snp_seen_r),
            .oneshot   (ctrl_r.oneshot),
            .ps        (ctrl_r.ps),
            .ivl       (ivl_r),
            .ld_ack    (ld_ack_t[i]),
            .exp_tgl   (exp_t[i]),
            .snap      (snap_t[i]),
            .snap_tgl  (stgl_t[i])
        );
    end

    logic [NCH-1:0] clr_mask;
    assign clr_mask = (bus_wr && bus_addr == AW'(OFS_PEND)) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= '0;
            stat_q   <= '0;
        end else begin
            if (bus_wr && bus_addr == AW'(OFS_MASK)) irq_en_q <= bus_wdata[NCH-1:0];
            stat_q <= (stat_q & ~clr_mask) | exp_evt;
        end
    end

    assign irq = |(stat_q & irq_en_q);

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (bus_addr == AW'(OFS_MASK))      rd_mux[NCH-1:0] = irq_en_q;
        else if (bus_addr == AW'(OFS_PEND)) rd_mux[NCH-1:0] = stat_q;
        for (int k = 0; k < NCH; k++) begin
            if (acc[k]) begin
                case (sub)
                    SUB_CTRL:   rd_mux = {24'h0, ctrl_v[k].oneshot, ctrl_v[k].ps, 2'b00,
                                          ctrl_v[k].load, ctrl_v[k].en};
                    SUB_IVL_LO: rd_mux = ivl_v[k][DATA_W-1:0];
                    SUB_IVL_HI: rd_mux = ivl_v[k][CW-1:DATA_W];
                    SUB_CNT_LO: rd_mux = cnt_v[k][DATA_W-1:0];
                    SUB_CNT_HI: rd_mux = hi_v[k];
                    default:    rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    bus_rdata,
    input logic           irq,
    input logic [NCH-1:0] irq_en_q,
    input logic [NCH-1:0] stat_q,
    input logic [NCH-1:0] en_vec,
    input logic [NCH-1:0] rl_vec,
    input logic [NCH-1:0] os_vec
);
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en_q != '0));

    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q != '0));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        localparam logic [AW-1:0] CA = AW'(16 + 32 * i);

        a_r7_pend_clear_only_w1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_q[i]) |-> $past(bus_wr && bus_addr == AW'(4) && bus_wdata[i]));

        a_r3_load_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rl_vec[i]) |-> $past(bus_wr && bus_addr == CA && bus_wdata[1]));

        a_r6_en_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_vec[i]) |-> ($past(os_vec[i]) ||
                                  $past(bus_wr && bus_addr == CA && !bus_wdata[0])));
    end
endmodule

bind dtmr_top dtmr_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .irq_en_q (irq_en_q),
    .stat_q   (stat_q),
    .en_vec   (en_vec),
    .rl_vec   (rl_vec),
    .os_vec   (os_vec)
);

// File: tb/dtmr_top_bench.sv
`timescale 1ns/1ps
module dtmr_top_bench;
    localparam int NCH = 3;
    localparam int AW  = 8;

    logic clk = 0, tclk = 0, rst_n = 0, trst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;

    always #5 clk = ~clk;
    always #7 tclk = ~tclk;

    int unsigned tcnt = 0;
    always @(posedge tclk) tcnt <= tcnt + 1;

    dtmr_top #(.NCH(NCH), .AW(AW)) u_dtmr_top (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .trst_n(trst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    function automatic logic [7:0] ca(int ch, int word);
        return 8'(16 + 32 * ch + 4 * word);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] lo, logic [63:0] hi);
        nchk++;
        if (act < lo || act > hi) begin
            nfail++;
            if (lo == hi) $display("FAIL %s actual=%0h expected=%0h", tag, act, lo);
            else          $display("FAIL %s actual=%0h expected=[%0h..%0h]", tag, act, lo, hi);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic idle_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_t(int n);
        repeat (n) @(posedge tclk);
        @(negedge clk);
    endtask

    task automatic wait_irq(string tag, output int unsigned t);
        int guard = 0;
        @(negedge clk);
        while (!irq && guard < 20000) begin @(negedge clk); guard++; end
        t = tcnt;
        if (!irq) chk({tag, " irq never rose"}, 0, 1, 1);
    endtask

    // periodic period expectation in timer clocks
    function automatic int unsigned period(int unsigned ivl, int unsigned ps);
        return (ivl + 1) << ps;
    endfunction

    logic [31:0] d, a, b, c, frozen0;
    int unsigned t1, t2, t0;

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (4) @(negedge clk);
        rst_n = 1; trst_n = 1;
        idle_clk(20);

        // R1 reset values
        chk("R1 irq", irq, 0, 0);
        rd(8'h00, d); chk("R1 mask", d, 0, 0);
        rd(8'h04, d); chk("R1 pend", d, 0, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            for (int w = 0; w < 5; w++) begin
                rd(ca(ch, w), d); chk($sformatf("R1 ch%0d word%0d", ch, w), d, 0, 0);
            end
        end

        // R2 control layout and interval readback
        wr(ca(1, 0), 32'hFFFF_FF7C);
        rd(ca(1, 0), d); chk("R2 ctrl fields", d, 32'h70, 32'h70);
        a = $urandom; b = $urandom;
        wr(ca(1, 1), a); wr(ca(1, 2), b);
        rd(ca(1, 1), d); chk("R2 ivl lo", d, a, a);
        rd(ca(1, 2), d); chk("R2 ivl hi", d, b, b);
        wr(ca(1, 0), 0);

        // R3 load without enable
        wr(ca(0, 1), 32'h0000_1234); wr(ca(0, 2), 32'h5);
        wr(ca(0, 0), 32'h2);
        rd(ca(0, 0), d); chk("R3 load pending", d, 2, 2);
        idle_clk(40);
        rd(ca(0, 0), d); chk("R3 load self-clear", d, 0, 0);
        rd(ca(0, 3), d); chk("R3 count lo", d, 32'h1234, 32'h1234);
        rd(ca(0, 4), d); chk("R3 count hi", d, 5, 5);

        // R11 free running, R4 rate with prescale 0
        wr(ca(0, 1), 32'hFFFF_FFFF); wr(ca(0, 2), 0);
        wr(ca(0, 0), 32'h3);
        idle_clk(40);
        rd(ca(0, 3), a);
        idle_t(1000);
        rd(ca(0, 3), b);
        chk("R11 inverted count rises", (~b > ~a) ? 1 : 0, 1, 1);
        chk("R4 ps0 rate", 64'(~b - ~a), 990, 1010);

        // R4 prescale 3
        wr(ca(0, 0), 0); idle_t(10);
        wr(ca(0, 0), 32'h33);
        idle_clk(40);
        rd(ca(0, 3), a);
        idle_t(1600);
        rd(ca(0, 3), b);
        chk("R4 ps3 rate", 64'(~b - ~a), 197, 203);

        // R10 disable freezes after sync delay
        wr(ca(0, 0), 32'h03); idle_clk(40);
        rd(ca(0, 3), c);
        wr(ca(0, 0), 0);
        idle_t(30);
        rd(ca(0, 3), a);
        idle_t(200);
        rd(ca(0, 3), b);
        chk("R10 count frozen", b, a, a);
        chk("R10 stop latency", 64'(~a - ~c), 0, 30);
        frozen0 = b;

        // R5 periodic with random interval and prescale
        wr(8'h00, 32'h4);
        for (int tr = 0; tr < 4; tr++) begin
            int unsigned ivl = 20 + ($urandom % 60);
            int unsigned ps  = $urandom % 3;
            wr(ca(2, 0), 0); idle_t(10);
            wr(ca(2, 1), ivl); wr(ca(2, 2), 0);
            wr(8'h04, 32'h7);
            wr(ca(2, 0), 32'h3 | (ps << 4));
            wait_irq("R5 first", t1);
            wr(8'h04, 32'h4);
            wait_irq("R5 second", t2);
            chk($sformatf("R5 period ivl=%0d ps=%0d", ivl, ps), t2 - t1,
                period(ivl, ps) - 2, period(ivl, ps) + 2);
            rd(ca(2, 0), d); chk("R5 enable kept", d[0], 1, 1);
        end

        // R6 single-shot on ch1 while ch2 runs masked
        wr(8'h00, 32'h2);
        wr(8'h04, 32'h7);
        wr(ca(1, 1), 50); wr(ca(1, 2), 0);
        t0 = tcnt;
        wr(ca(1, 0), 32'h83);
        wait_irq("R6 expiry", t1);
        chk("R6 expiry time", t1 - t0, 51, 68);
        idle_clk(10);
        rd(ca(1, 0), d); chk("R6 enable cleared", d, 32'h80, 32'h80);
        idle_clk(40);
        rd(ca(1, 3), d); chk("R6 count held 0", d, 0, 0);
        wr(8'h04, 32'h2);
        idle_t(300);
        rd(8'h04, d); chk("R6 no second expiry", d[1], 0, 0);

        // R8 masking, R12 independence
        chk("R12 ch2 pending while ch1 single-shot", d[2], 1, 1);
        chk("R8 masked pending keeps irq low", irq, 0, 0);
        wr(8'h00, 32'h6);
        chk("R8 unmasked pending raises irq", irq, 1, 1);
        rd(ca(0, 3), d); chk("R12 ch0 untouched", d, frozen0, frozen0);

        // R7 write-one-to-clear
        wr(ca(2, 0), 0); idle_t(20);
        wr(8'h04, 32'h7); idle_clk(4);
        rd(8'h04, d); chk("R7 stopped channel clean", d, 0, 0);
        wr(ca(2, 1), 3); wr(ca(2, 0), 32'h83);
        idle_t(40);
        wr(8'h04, 32'h2);
        rd(8'h04, d); chk("R7 zero bit keeps pending", d[2], 1, 1);
        wr(8'h04, 32'h4);
        rd(8'h04, d); chk("R7 one bit clears", d[2], 0, 0);
        chk("R8 irq drops after clear", irq, 0, 0);

        // R9 coherent read across high-word borrow
        begin
            logic [63:0] start = 64'h1_0000_0040, v, prev;
            bit saw_hi1 = 0, saw_hi0 = 0;
            prev = start;
            wr(ca(0, 1), 32'h40); wr(ca(0, 2), 1);
            wr(ca(0, 0), 32'h3);
            idle_clk(10);
            for (int k = 0; k < 12; k++) begin
                logic [31:0] lo, hi;
                rd(ca(0, 3), lo);
                idle_clk(17);
                rd(ca(0, 4), hi);
                v = {hi, lo};
                if (hi == 1) saw_hi1 = 1;
                if (hi == 0) saw_hi0 = 1;
                chk($sformatf("R9 sample %0d coherent", k), v, start - 400, prev);
                prev = v;
            end
            chk("R9 crossed high word", {62'd0, saw_hi1, saw_hi0}, 3, 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule